// File: doc/BRIEF.md
# Shared-Pin Address/Data Byte Memory

This block is a small memory slave that sits on a bus whose lines carry the address and the data in turn. A master opens a transaction with a start strobe and puts the address on the shared lines in that cycle. The slave captures the address. In the next cycle the same lines carry either the byte to be stored, or the byte the slave returns. Each transaction moves one byte, so the bus delivers one byte every two cycles.

A build-time parameter selects a split-address variant. Here the address is twice as wide as the lines. The upper half travels in the first cycle, the lower half in the second, and the data moves in the third, which gives one byte every three cycles. The shared lines are shown as a pad-style triple: an input, an output and an output-enable. The output-enable goes high only while the slave is returning read data.

Top module: `muxbus_mem`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, bus_oe_o is 0 and bus_o is 0.
- R2: A cycle with start_i=1 while the slave is idle is an address cycle; bus_i is captured as the address, and with we_i=1 the bus_i value in the following data cycle is stored at that address.
- R3: With we_i=0 in the address cycle, the slave drives bus_oe_o=1 and bus_o equal to the byte stored at the captured address during the data cycle that follows.
- R4: bus_oe_o is 1 only in a read data cycle and 0 in every other cycle, including address cycles and write data cycles; whenever bus_oe_o is 0, bus_o is 0.
- R5: With SPLIT_ADDR=1 the address is 2*DATA_W bits wide: bus_i carries the upper half in the start cycle and the lower half in the next cycle, and data moves in the third cycle; with SPLIT_ADDR=0 the address is DATA_W bits wide.
- R6: start_i held high during an address or data phase of a running transaction starts nothing: no extra data cycle follows, and bus_oe_o stays 0 in the cycle after the data cycle.
- R7: A new transaction may begin in the cycle immediately after a data cycle, with no idle cycle in between.
- R8: The direction is taken from we_i in the start cycle only; a change of we_i in later phases does not alter the stored contents or the read output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the first address cycle of a transaction |
| we_i | input | 1 | 1 = write, 0 = read; sampled with start_i |
| bus_i | input | DATA_W | Shared lines as seen by the slave: address or write data |
| bus_o | output | DATA_W | Read data the slave drives onto the shared lines |
| bus_oe_o | output | 1 | High while the slave drives the shared lines |

## Verification
The assertions assume that the master raises start_i with a valid we_i, and that the master never expects an address cycle to be accepted while a transaction is still running. For that reason the checker's shadow of the phase counts starts only from idle. The bench drives every input at the falling edge, so each level is stable across the rising edge that samples it. On purpose it holds start_i high and flips we_i inside running transactions, to show that both are ignored there. It reads back only addresses it has first written, so no check depends on the contents of an uninitialised array.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ALO  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;
endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter bit SPLIT_ADDR = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic we_i,
  output logic cap_hi_o,
  output logic cap_lo_o,
  output logic data_ph_o,
  output logic wr_o
);
  phase_e phase_q, phase_d;
  logic   we_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) phase_d = SPLIT_ADDR ? PH_ALO : PH_DATA;
      PH_ALO:  phase_d = PH_DATA;
      PH_DATA: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      we_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (cap_hi_o) we_q <= we_i;  // direction frozen at start
    end
  end

  assign cap_hi_o  = (phase_q == PH_IDLE) && start_i;
  assign cap_lo_o  = (phase_q == PH_ALO);
  assign data_ph_o = (phase_q == PH_DATA);
  assign wr_o      = we_q;
endmodule

// File: rtl/muxbus_addr_latch.sv
module muxbus_addr_latch #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          SPLIT_ADDR = 1'b0,
  parameter int unsigned ADDR_W     = SPLIT_ADDR ? 2 * DATA_W : DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_hi_i,
  input  logic              cap_lo_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [ADDR_W-1:0] addr_o
);
  generate
    if (SPLIT_ADDR) begin : g_split
      logic [DATA_W-1:0] hi_q, lo_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hi_q <= '0;
          lo_q <= '0;
        end else begin
          if (cap_hi_i) hi_q <= bus_i;
          if (cap_lo_i) lo_q <= bus_i;
        end
      end
      assign addr_o = {hi_q, lo_q};
    end else begin : g_flat
      logic [DATA_W-1:0] a_q;
      logic              unused_lo;
      assign unused_lo = cap_lo_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       a_q <= '0;
        else if (cap_hi_i) a_q <= bus_i;
      end
      assign addr_o = a_q;
    end
  endgenerate
endmodule

// File: rtl/muxbus_store.sv
module muxbus_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  // async read: data must be on the lines within the data cycle
  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/muxbus_mem.sv
module muxbus_mem #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          SPLIT_ADDR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  localparam int unsigned ADDR_W = SPLIT_ADDR ? 2 * DATA_W : DATA_W;

  logic              cap_hi, cap_lo, data_ph, wr;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdata;

  muxbus_seq #(.SPLIT_ADDR(SPLIT_ADDR)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .we_i      (we_i),
    .cap_hi_o  (cap_hi),
    .cap_lo_o  (cap_lo),
    .data_ph_o (data_ph),
    .wr_o      (wr)
  );

  muxbus_addr_latch #(
    .DATA_W     (DATA_W),
    .SPLIT_ADDR (SPLIT_ADDR),
    .ADDR_W     (ADDR_W)
  ) i_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_hi_i (cap_hi),
    .cap_lo_i (cap_lo),
    .bus_i    (bus_i),
    .addr_o   (addr)
  );

  muxbus_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
    .clk_i   (clk_i),
    .wr_en_i (data_ph && wr),
    .addr_i  (addr),
    .wdata_i (bus_i),
    .rdata_o (rdata)
  );

  assign bus_oe_o = data_ph && !wr;
  assign bus_o    = bus_oe_o ? rdata : '0;
endmodule

// File: rtl/muxbus_mem_chk.sv
module muxbus_mem_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter bit          SPLIT_ADDR = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              we_i,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o
);
  // independent shadow of the transaction phase: 0 idle, 1 data
  logic [1:0] sh_cnt;
  logic       sh_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cnt <= 2'd0;
      sh_we  <= 1'b0;
    end else if (sh_cnt == 2'd0) begin
      if (start_i) begin
        sh_cnt <= SPLIT_ADDR ? 2'd2 : 2'd1;
        sh_we  <= we_i;
      end
    end else begin
      sh_cnt <= sh_cnt - 2'd1;
    end
  end

  always_comb begin
    if (!rst_ni) begin
      a_r1_released_in_reset: assert (!bus_oe_o);
    end
  end

  a_r4_drive_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (sh_cnt == 2'd1 && !sh_we));

  a_r3_drive_in_read_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_cnt == 2'd1 && !sh_we) |-> bus_oe_o);

  a_r4_quiet_when_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> (bus_o == '0));

  a_r6_single_data_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |=> !bus_oe_o);
endmodule

bind muxbus_mem muxbus_mem_chk #(.DATA_W(DATA_W), .SPLIT_ADDR(SPLIT_ADDR)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .we_i     (we_i),
  .bus_o    (bus_o),
  .bus_oe_o (bus_oe_o)
);

// File: tb/test_muxbus_mem.sv
`timescale 1ns/1ps
module test_muxbus_mem;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // two-phase instance, 8-bit lines
  logic       start_a = 1'b0, we_a = 1'b0;
  logic [7:0] bus_a = '0, out_a;
  logic       oe_a;

  // split-address instance, 4-bit lines, 8-bit address
  logic       start_b = 1'b0, we_b = 1'b0;
  logic [3:0] bus_b = '0, out_b;
  logic       oe_b;

  muxbus_mem #(.DATA_W(8), .SPLIT_ADDR(1'b0)) i_muxbus_mem (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .we_i(we_a),
    .bus_i(bus_a), .bus_o(out_a), .bus_oe_o(oe_a)
  );

  muxbus_mem #(.DATA_W(4), .SPLIT_ADDR(1'b1)) i_muxbus_mem_split (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .we_i(we_b),
    .bus_i(bus_b), .bus_o(out_b), .bus_oe_o(oe_b)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // {we, addr, data}; for reads data is the expected byte
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'h00, 8'hA5}, {1'b1, 8'hFF, 8'h5A},
    {1'b1, 8'h3C, 8'h01}, {1'b1, 8'h80, 8'hFE},
    {1'b0, 8'hFF, 8'h5A}, {1'b0, 8'h00, 8'hA5},
    {1'b0, 8'h80, 8'hFE}, {1'b0, 8'h3C, 8'h01}
  };

  // two-phase transaction; we_i is flipped in the data cycle (R8)
  task automatic txn2(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic start_in_data, output logic oe, output logic [7:0] rd);
    @(negedge clk);
    start_a = 1'b1; we_a = we; bus_a = a;
    @(negedge clk);
    start_a = start_in_data; we_a = ~we; bus_a = we ? d : 8'h00;
    #2;
    oe = oe_a; rd = out_a;
  endtask

  // three-phase transaction; start held and we_i flipped after cycle 1
  task automatic txn3(input logic we, input logic [3:0] hi, input logic [3:0] lo,
                      input logic [3:0] d, output logic oe, output logic [3:0] rd);
    @(negedge clk);
    start_b = 1'b1; we_b = we; bus_b = hi;
    @(negedge clk);
    start_b = 1'b1; we_b = ~we; bus_b = lo;
    #2;
    chk("R4 oe low in low-address phase", {7'd0, oe_b}, 8'd0);
    @(negedge clk);
    start_b = 1'b0; bus_b = we ? d : 4'h0;
    #2;
    oe = oe_b; rd = out_b;
  endtask

  initial begin
    logic       oe;
    logic [7:0] rd;
    logic [3:0] rd4;

    repeat (3) @(negedge clk);
    chk("R1 reset oe", {6'd0, oe_a, oe_b}, 8'd0);
    chk("R1 reset bus_o", out_a | {4'd0, out_b}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R1 oe after release", {6'd0, oe_a, oe_b}, 8'd0);

    // back-to-back vectors (R2, R3, R4, R7)
    for (int i = 0; i < 8; i++) begin
      txn2(VEC[i][16], VEC[i][15:8], VEC[i][7:0], 1'b0, oe, rd);
      if (VEC[i][16]) begin
        chk("R4 oe low in write data cycle", {7'd0, oe}, 8'd0);
      end else begin
        chk("R3 oe high in read data cycle", {7'd0, oe}, 8'd1);
        chk("R2 R3 R7 read data", rd, VEC[i][7:0]);
      end
    end

    // R8: earlier reads had we_i=1 in data cycle; contents untouched
    txn2(1'b0, 8'hFF, 8'h00, 1'b0, oe, rd);
    chk("R8 no write from late we_i", rd, 8'h5A);

    // R6: start held in write data cycle is ignored
    txn2(1'b1, 8'h3C, 8'h77, 1'b1, oe, rd);
    @(negedge clk);
    start_a = 1'b0;
    #2;
    chk("R6 no transaction from ignored start", {7'd0, oe_a}, 8'd0);
    txn2(1'b0, 8'h3C, 8'h00, 1'b0, oe, rd);
    chk("R6 write intact after ignored start", rd, 8'h77);
    @(negedge clk);
    start_a = 1'b0;
    #2;
    chk("R4 oe low when idle", {7'd0, oe_a}, 8'd0);

    // split-address mode (R5, R6, R8)
    txn3(1'b1, 4'h3, 4'hC, 4'h9, oe, rd4);
    chk("R4 oe low in split write data", {7'd0, oe}, 8'd0);
    txn3(1'b1, 4'hC, 4'h3, 4'h6, oe, rd4);
    txn3(1'b0, 4'h3, 4'hC, 4'h0, oe, rd4);
    chk("R5 split read oe", {7'd0, oe}, 8'd1);
    chk("R5 split read 0x3C", {4'd0, rd4}, 8'h09);
    txn3(1'b0, 4'hC, 4'h3, 4'h0, oe, rd4);
    chk("R5 split read 0xC3", {4'd0, rd4}, 8'h06);
    txn3(1'b0, 4'h3, 4'hC, 4'h0, oe, rd4);
    chk("R8 split no write from late we_i", {4'd0, rd4}, 8'h09);
    @(negedge clk);
    #2;
    chk("R6 split idle after data", {7'd0, oe_b}, 8'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(64'd4_000_000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule